// File: doc/BRIEF.md
# Banked Memory Address Mapper

This block sits between an 8-bit CPU with a 64K address space and a 128K RAM built as four 32K blocks. It turns each 16-bit CPU memory address into a 17-bit physical address and drives the RAM chip select.

The upper half of CPU space (A15 = 1) always lands in the topmost physical block. The lower half (A15 = 0) lands in whichever block a 2-bit bank latch names. Software loads that latch with an I/O write to port 0x1F. The latch cannot be read back, and it clears to zero on reset.

A system clock samples the I/O write strobe, so a bank change takes effect from the clock edge that captures the write.

Top module: `bank_mapper`

## Requirements
- R1: After reset the bank latch is 0, so CPU address 0x1234 maps to physical 0x01234.
- R2: When A15 is 0, the physical address is {bank[1:0], A[14:0]}. Bank 0 is the lowest 32K block and bank 3 the highest.
- R3: When A15 is 1, the physical address is {2'b11, A[14:0]} for every bank value.
- R4: A clock edge that sees iorq_ni low, wr_ni low and addr_i[7:0] equal to 0x1F loads data_i[1:0] into the bank latch. Data bits 7:2 are ignored.
- R5: Only the low address byte is decoded. Writes to any other low-byte value leave the bank unchanged, and addr_i[15:8] does not affect the decode.
- R6: A cycle with iorq_ni high (a memory write) or with wr_ni high (an I/O read, including a read of port 0x1F) leaves the bank unchanged.
- R7: ram_cs_o is high exactly when mreq_ni is low.
- R8: A loaded bank value persists unchanged until the next qualifying write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples bus strobes |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 16 | CPU address bus |
| data_i | input | 8 | CPU data bus (write data) |
| iorq_ni | input | 1 | Active-low I/O request |
| wr_ni | input | 1 | Active-low write strobe |
| mreq_ni | input | 1 | Active-low memory request |
| paddr_o | output | 17 | Physical RAM address |
| ram_cs_o | output | 1 | RAM chip select, active high |

## Verification
The assertions assume that the bus strobes are synchronous to clk_i and stable around each rising edge. They also assume that a qualifying I/O write is held for at least one edge, so "load, then stable" can be checked cycle by cycle. The bench changes every input only on the falling edge and holds each I/O write strobe across exactly one rising edge. It sweeps every bank value against addresses spread over both halves of CPU space.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;
  localparam int unsigned CPU_AW   = 16;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned BLK_BITS = 2;
  localparam int unsigned IO_AW    = 8;
  localparam logic [IO_AW-1:0] BANK_PORT = 8'h1F;
endpackage

// File: rtl/bank_io_decode.sv
module bank_io_decode #(
  parameter int unsigned IO_AW = 8,
  parameter logic [IO_AW-1:0] PORT = '0
) (
  input  logic [IO_AW-1:0] io_addr_i,
  input  logic             iorq_ni,
  input  logic             wr_ni,
  output logic             load_o
);
  assign load_o = !iorq_ni && !wr_ni && (io_addr_i == PORT);
endmodule

// File: rtl/bank_latch.sv
module bank_latch #(
  parameter int unsigned BLK_BITS = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [BLK_BITS-1:0] data_i,
  output logic [BLK_BITS-1:0] bank_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     bank_o <= '0;
    else if (load_i) bank_o <= data_i;
  end

  AST_BANK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> bank_o == $past(data_i)); // R4
  AST_BANK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(bank_o)); // R8
endmodule

// File: rtl/bank_addr_xlate.sv
module bank_addr_xlate #(
  parameter int unsigned CPU_AW   = 16,
  parameter int unsigned BLK_BITS = 2,
  localparam int unsigned OFF_W   = CPU_AW - 1,
  localparam int unsigned PA_W    = OFF_W + BLK_BITS
) (
  input  logic [CPU_AW-1:0]   addr_i,
  input  logic [BLK_BITS-1:0] bank_i,
  output logic [PA_W-1:0]     paddr_o
);
  logic [BLK_BITS-1:0] blk_sel;

  generate
    if (BLK_BITS == 1) begin : g_one_bit
      assign blk_sel = addr_i[CPU_AW-1] | bank_i;
    end else begin : g_multi_bit
      // upper window pinned to the top block
      assign blk_sel = addr_i[CPU_AW-1] ? {BLK_BITS{1'b1}} : bank_i;
    end
  endgenerate

  assign paddr_o = {blk_sel, addr_i[OFF_W-1:0]};
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import bank_mapper_pkg::*;
#(
  parameter int unsigned AW  = CPU_AW,
  parameter int unsigned DW  = DATA_W,
  parameter int unsigned BB  = BLK_BITS,
  parameter int unsigned IAW = IO_AW,
  parameter logic [IAW-1:0] PORT = BANK_PORT,
  localparam int unsigned PA_W = AW - 1 + BB
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   data_i,
  input  logic            iorq_ni,
  input  logic            wr_ni,
  input  logic            mreq_ni,
  output logic [PA_W-1:0] paddr_o,
  output logic            ram_cs_o
);
  logic          load;
  logic [BB-1:0] bank;
  logic          unused_bits;

  assign unused_bits = ^{data_i[DW-1:BB], addr_i[AW-1:IAW]};

  bank_io_decode #(.IO_AW(IAW), .PORT(PORT)) u_dec (
    .io_addr_i (addr_i[IAW-1:0]),
    .iorq_ni   (iorq_ni),
    .wr_ni     (wr_ni),
    .load_o    (load)
  );

  bank_latch #(.BLK_BITS(BB)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .data_i (data_i[BB-1:0]),
    .bank_o (bank)
  );

  bank_addr_xlate #(.CPU_AW(AW), .BLK_BITS(BB)) u_xlate (
    .addr_i  (addr_i),
    .bank_i  (bank),
    .paddr_o (paddr_o)
  );

  assign ram_cs_o = ~mreq_ni;

  AST_UPPER_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i[AW-1] |-> paddr_o[PA_W-1:AW-1] == {BB{1'b1}}); // R3
  AST_OFFSET_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    paddr_o[AW-2:0] == addr_i[AW-2:0]); // R2
  AST_LOWER_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_i[AW-1] |-> paddr_o[PA_W-1:AW-1] == bank); // R2
  AST_NO_STRAY_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iorq_ni || wr_ni) |=> $stable(bank)); // R6
  AST_CS_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_cs_o != mreq_ni); // R7
endmodule

// File: tb/sim_bank_mapper.sv
`timescale 1ns/1ps
module sim_bank_mapper;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr_i = '0;
  logic [7:0]  data_i = '0;
  logic        iorq_ni = 1'b1, wr_ni = 1'b1, mreq_ni = 1'b1;
  logic [16:0] paddr_o;
  logic        ram_cs_o;

  int checks = 0, errors = 0;
  logic [1:0] exp_bank = 2'd0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  bank_mapper u0 (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic io_cycle(logic [15:0] a, logic [7:0] d, logic iorq, logic wr);
    @(negedge clk_i);
    addr_i = a; data_i = d; iorq_ni = iorq; wr_ni = wr; mreq_ni = 1'b1;
    @(negedge clk_i);
    iorq_ni = 1'b1; wr_ni = 1'b1;
  endtask

  task automatic map_chk(string tag, logic [15:0] a);
    logic [16:0] exp;
    @(negedge clk_i);
    addr_i = a; mreq_ni = 1'b0;
    #1;
    exp = a[15] ? {2'b11, a[14:0]} : {exp_bank, a[14:0]};
    chk(tag, {15'd0, paddr_o}, {15'd0, exp});
    chk("R7", {31'd0, ram_cs_o}, 32'd1);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: reset state
    map_chk("R1", 16'h1234);
    map_chk("R1", 16'h0000);

    // R2 / R3: sweep every bank over both halves, junk in high data bits (R4)
    for (int b = 0; b < 4; b++) begin
      io_cycle({8'hA5, 8'h1F}, {6'(b * 11 + 7), 2'(b)}, 1'b0, 1'b0);
      exp_bank = 2'(b);
      for (int a = 0; a < 65536; a += 4093) begin
        if (a[15]) map_chk("R3", 16'(a)); else map_chk("R2", 16'(a));
      end
      map_chk("R2", 16'h7FFF);
      map_chk("R3", 16'h8000);
      map_chk("R3", 16'hFFFF);
      map_chk("R4", 16'h4000);
    end

    // R5: other low-byte ports do not load (bank is 3 here)
    for (int p = 0; p < 256; p++) begin
      if (p != 8'h1F) io_cycle({8'h1F, 8'(p)}, 8'h00, 1'b0, 1'b0);
    end
    map_chk("R5", 16'h0ABC);
    // R5: upper address byte irrelevant to decode
    io_cycle(16'hFF1F, 8'hFD, 1'b0, 1'b0);
    exp_bank = 2'd1;
    map_chk("R5", 16'h2222);

    // R6: I/O read of the port and memory write do not load
    io_cycle(16'h001F, 8'h02, 1'b0, 1'b1);
    map_chk("R6", 16'h3333);
    io_cycle(16'h001F, 8'h03, 1'b1, 1'b0);
    map_chk("R6", 16'h3334);

    // R8: value persists over idle cycles
    repeat (20) @(negedge clk_i);
    map_chk("R8", 16'h5555);

    // R7: chip select follows memory request
    for (int m = 0; m < 2; m++) begin
      @(negedge clk_i);
      mreq_ni = 1'(m);
      #1;
      chk("R7", {31'd0, ram_cs_o}, {31'd0, ~1'(m)});
    end

    // R1: reset clears a loaded bank
    io_cycle(16'h001F, 8'h02, 1'b0, 1'b0);
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    exp_bank = 2'd0;
    map_chk("R1", 16'h1234);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule